// File: doc/BRIEF.md
# System clock source selector and power-of-two divider

This block produces the system clock of a small controller from one of five oscillator sources. Four raw oscillator levels enter the block: a precision internal oscillator, an external oscillator, a low-power oscillator and a real-time-clock oscillator. A fifth source is the low-power oscillator slowed by eight inside the block. The chosen source is the undivided clock. A free-running 7-bit counter of its rising edges then divides it by 1, 2, 4, 8, 16, 32, 64 or 128.

Software controls the block through one 8-bit register. A write sets the source and the divide ratio. A read returns both fields and a ready flag. That flag shows whether the written divide ratio has reached the output. The whole block runs on a fast sampling clock `clk`. Oscillator levels are synchronised, and the output `sysclk_o` is a level sampled in that domain.

A source change passes through three phases. First the old source is gated off at one of its falling edges. The output is then held low. Finally the new source is let through at one of its own falling edges. The block has a separate output that flags any divide setting other than divide-by-1, so that sleep-entry logic can refuse to enter a low-power mode.

Top module: `sysclk_gen`

## Requirements
- R1: After reset the register reads 0x12: ready = 0, divide field (bits 6:4) = 001, source field (bits 2:0) = 010, and the low-power oscillator divided by 8 drives the undivided clock.
- R2: Bit 3 always reads 0. Bit 7 is read-only: a write never sets it, and any write clears it on the next cycle.
- R3: A write whose bits 2:0 hold a reserved code (101, 110, 111) leaves the source field and the active source unchanged. The divide field of the same write is still taken.
- R4: Source codes are 000 = precision internal, 001 = external, 011 = real-time-clock, 100 = low-power oscillator (raw input index 0, 1, 3, 2). At divide-by-1 the output follows the selected input two sampling cycles late plus one register stage.
- R5: A source change lets the old source run until its next falling edge. The output is then held low until a falling edge of the newest requested source, which is then passed through. A request that changes during a switch redirects it.
- R6: Divide code d (bits 6:4) gives an output period of 2^d undivided periods. Codes 000 to 111 give ratios 1 to 128.
- R7: A new divide ratio takes effect only on the undivided rising edge that wraps the 7-bit counter from 127 to 0. This happens at most 128 undivided periods after the write. The ready flag is set on that cycle unless a write occurs at the same time.
- R8: `div_active_o` is 1 exactly when the divide field is not 000.
- R9: Source code 010 gives a clock whose period is eight periods of the low-power oscillator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | 4 | Raw oscillator levels: 0 precision, 1 external, 2 low-power, 3 real-time-clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value {ready, divide, 0, source} |
| sysclk_o | output | 1 | Divided system clock level |
| div_active_o | output | 1 | High when the divide setting is not divide-by-1 |

## Verification
The hardest case to reach is a switch whose target changes while the old source is still draining. To force it, the bench writes one source and then another only a cycle later, so the second request lands inside the drain or gap phase. Ratio changes need 128 undivided rising edges before they apply, so the bench also runs long stretches on slow sources to reach several counter wraps. It times the delay until ready rises and measures the output period afterwards. A behavioural model compares the output and the register on every cycle.

// File: rtl/sysclk_gen_pkg.sv
package sysclk_gen_pkg;

    localparam int REG_W       = 8;
    localparam int FIELD_W     = 3;
    localparam int NUM_SRC     = 5;

    // raw oscillator input indices
    localparam int OSC_PREC    = 0;
    localparam int OSC_EXT     = 1;
    localparam int OSC_LP      = 2;
    localparam int OSC_RTC     = 3;

    typedef enum logic [FIELD_W-1:0] {
        SRC_PREC  = 3'd0,
        SRC_EXT   = 3'd1,
        SRC_LPDIV = 3'd2,
        SRC_RTC   = 3'd3,
        SRC_LP    = 3'd4
    } src_code_e;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_WAIT  = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic               ready;
        logic [FIELD_W-1:0] div;
        logic [FIELD_W-1:0] src;
    } ctrl_t;

    localparam logic [FIELD_W-1:0] RST_DIV = 3'd1;
    localparam logic [FIELD_W-1:0] RST_SRC = SRC_LPDIV;

    function automatic logic src_code_ok(input logic [FIELD_W-1:0] code);
        return code <= SRC_LP;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input ctrl_t c);
        return {c.ready, c.div, 1'b0, c.src};
    endfunction

endpackage

// File: rtl/sysclk_gen_regs.sv
module sysclk_gen_regs
    import sysclk_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             apply_i,
    output ctrl_t            ctrl_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.ready <= 1'b0;
            ctrl_q.div   <= RST_DIV;
            ctrl_q.src   <= RST_SRC;
        end else if (wr_en) begin
            ctrl_q.div   <= wr_data[6:4];
            ctrl_q.ready <= 1'b0;
            if (src_code_ok(wr_data[FIELD_W-1:0]))
                ctrl_q.src <= wr_data[FIELD_W-1:0];
        end else if (apply_i) begin
            ctrl_q.ready <= 1'b1;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/sysclk_gen_srcmux.sv
module sysclk_gen_srcmux
    import sysclk_gen_pkg::*;
#(
    parameter int NUM_OSC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LPDIV_W     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic [FIELD_W-1:0] target_i,
    output logic               gated_o,
    output logic               undiv_o,
    output logic               sw_wait_o
);

    // synchroniser chain, one register row per stage
    logic [NUM_OSC-1:0] sync_q [SYNC_STAGES];

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= '0;
                    else     sync_q[g] <= osc_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= '0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    logic [NUM_OSC-1:0] osc_s;
    assign osc_s = sync_q[SYNC_STAGES-1];

    // low-power oscillator divided by eight
    logic               lp_prev_q;
    logic [LPDIV_W-1:0] lp_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_prev_q <= 1'b0;
            lp_cnt_q  <= '0;
        end else begin
            lp_prev_q <= osc_s[OSC_LP];
            if (osc_s[OSC_LP] && !lp_prev_q)
                lp_cnt_q <= lp_cnt_q + 1'b1;
        end
    end

    // source levels indexed by source code
    logic [NUM_SRC-1:0] lvl;
    logic [NUM_SRC-1:0] lvl_prev_q;
    logic [NUM_SRC-1:0] fall;

    always_comb begin
        lvl            = '0;
        lvl[SRC_PREC]  = osc_s[OSC_PREC];
        lvl[SRC_EXT]   = osc_s[OSC_EXT];
        lvl[SRC_LPDIV] = lp_cnt_q[LPDIV_W-1];
        lvl[SRC_RTC]   = osc_s[OSC_RTC];
        lvl[SRC_LP]    = osc_s[OSC_LP];
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_prev_q <= '0;
        else     lvl_prev_q <= lvl;
    end

    assign fall = lvl_prev_q & ~lvl;

    // switch controller
    sw_state_e          st_q;
    logic [FIELD_W-1:0] cur_q;
    logic               undiv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SW_RUN;
            cur_q <= RST_SRC;
        end else begin
            unique case (st_q)
                SW_RUN: begin
                    if (target_i != cur_q) st_q <= SW_DRAIN;
                end
                SW_DRAIN: begin
                    if (fall[cur_q]) st_q <= SW_WAIT;
                end
                SW_WAIT: begin
                    if (fall[target_i]) begin
                        cur_q <= target_i;
                        st_q  <= SW_RUN;
                    end
                end
                default: st_q <= SW_RUN;
            endcase
        end
    end

    assign gated_o = (st_q != SW_WAIT) ? lvl[cur_q] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) undiv_q <= 1'b0;
        else     undiv_q <= gated_o;
    end

    assign undiv_o   = undiv_q;
    assign sw_wait_o = (st_q == SW_WAIT);

endmodule

// File: rtl/sysclk_gen_divider.sv
module sysclk_gen_divider
    import sysclk_gen_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gated_i,
    input  logic               undiv_i,
    input  logic [FIELD_W-1:0] div_sel_i,
    output logic               wrap_o,
    output logic [FIELD_W-1:0] act_o,
    output logic               sysclk_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0]   cnt_q;
    logic [FIELD_W-1:0] act_q;
    logic               rise;
    logic [FIELD_W-1:0] tap;

    assign rise   = gated_i && !undiv_i;
    assign wrap_o = rise && (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= RST_DIV;
        end else begin
            if (rise)   cnt_q <= cnt_q + 1'b1;
            if (wrap_o) act_q <= div_sel_i;
        end
    end

    assign tap      = act_q - 1'b1;
    assign sysclk_o = (act_q == '0) ? undiv_i : cnt_q[tap];
    assign act_o    = act_q;

endmodule

// File: rtl/sysclk_gen.sv
module sysclk_gen
    import sysclk_gen_pkg::*;
#(
    parameter int NUM_OSC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic               sysclk_o,
    output logic               div_active_o
);

    ctrl_t              ctrl;
    logic               gated;
    logic               undiv;
    logic               sw_wait;
    logic               wrap;
    logic [FIELD_W-1:0] act_div;

    sysclk_gen_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .apply_i (wrap),
        .ctrl_o  (ctrl)
    );

    sysclk_gen_srcmux #(
        .NUM_OSC     (NUM_OSC),
        .SYNC_STAGES (SYNC_STAGES),
        .LPDIV_W     (3)
    ) u_srcmux (
        .clk       (clk),
        .rst       (rst),
        .osc_i     (osc_i),
        .target_i  (ctrl.src),
        .gated_o   (gated),
        .undiv_o   (undiv),
        .sw_wait_o (sw_wait)
    );

    sysclk_gen_divider #(
        .CNT_W (CNT_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .gated_i   (gated),
        .undiv_i   (undiv),
        .div_sel_i (ctrl.div),
        .wrap_o    (wrap),
        .act_o     (act_div),
        .sysclk_o  (sysclk_o)
    );

    assign rd_data      = pack_status(ctrl);
    assign div_active_o = (ctrl.div != '0);

endmodule

// File: rtl/sysclk_gen_chk.sv
module sysclk_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       div_active_o,
    input logic       sw_wait,
    input logic       undiv,
    input logic       wrap,
    input logic [2:0] act_div
);

    assert_bit3_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_data[3]);

    assert_ready_clear_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_data[7]);

    assert_reserved_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[2:0] > 3'd4) |=> $stable(rd_data[2:0]));

    assert_gap_low_R5: assert property (@(posedge clk) disable iff (rst)
        sw_wait |=> !undiv);

    assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_div));

    assert_ready_set_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !wr_en) |=> rd_data[7]);

    assert_div_flag_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (div_active_o == ($past(wr_data[6:4]) != 3'd0)));

endmodule

bind sysclk_gen sysclk_gen_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .div_active_o (div_active_o),
    .sw_wait      (sw_wait),
    .undiv        (undiv),
    .wrap         (wrap),
    .act_div      (act_div)
);

// File: tb/sysclk_gen_tb_top.sv
module sysclk_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] osc = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sysclk;
    logic       div_active;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysclk_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .osc_i        (osc),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .sysclk_o     (sysclk),
        .div_active_o (div_active)
    );

    // oscillator stimulus: half periods 3, 5, 2, 7 sampling cycles
    int ncyc = 0;
    always @(negedge clk) begin
        ncyc++;
        osc[0] <= ((ncyc / 3) % 2) == 1;
        osc[1] <= ((ncyc / 5) % 2) == 1;
        osc[2] <= ((ncyc / 2) % 2) == 1;
        osc[3] <= ((ncyc / 7) % 2) == 1;
    end

    // behavioural reference model, advanced on each rising edge
    bit   m_s1 [4];
    bit   m_s2 [4];
    bit   m_lp_prev;
    int   m_lp_cnt;
    bit   m_prev [5];
    int   m_state;     // 0 run, 1 draining old, 2 gap
    int   m_cur;
    int   m_src, m_div, m_act, m_cnt;
    bit   m_ready, m_undiv;
    bit   m_valid = 1'b0;

    function automatic bit m_level(int code);
        case (code)
            0: return m_s2[0];
            1: return m_s2[1];
            2: return ((m_lp_cnt / 4) % 2) == 1;
            3: return m_s2[3];
            default: return m_s2[2];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
            for (int i = 0; i < 5; i++) m_prev[i] = 0;
            m_lp_prev = 0; m_lp_cnt = 0;
            m_state = 0; m_cur = 2; m_src = 2; m_div = 1; m_act = 1;
            m_cnt = 0; m_ready = 0; m_undiv = 0;
            m_valid = 1'b1;
        end else begin
            bit lv [5];
            bit g, rise, wrap, lp_now;
            int nstate, ncur;
            for (int i = 0; i < 5; i++) lv[i] = m_level(i);
            g    = (m_state != 2) ? lv[m_cur] : 1'b0;
            rise = g && !m_undiv;
            wrap = rise && (m_cnt == 127);
            nstate = m_state; ncur = m_cur;
            if (m_state == 0 && m_src != m_cur) nstate = 1;
            else if (m_state == 1 && m_prev[m_cur] && !lv[m_cur]) nstate = 2;
            else if (m_state == 2 && m_prev[m_src] && !lv[m_src]) begin
                nstate = 0; ncur = m_src;
            end
            lp_now = m_s2[2];
            if (lp_now && !m_lp_prev) m_lp_cnt = (m_lp_cnt + 1) % 8;
            m_lp_prev = lp_now;
            for (int i = 0; i < 5; i++) m_prev[i] = lv[i];
            for (int i = 0; i < 4; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = osc[i]; end
            if (wrap) m_act = m_div;
            if (rise) m_cnt = (m_cnt + 1) % 128;
            m_undiv = g;
            m_state = nstate; m_cur = ncur;
            if (wr_en) begin
                m_div = int'(wr_data[6:4]);
                if (wr_data[2:0] <= 3'd4) m_src = int'(wr_data[2:0]);
                m_ready = 0;
            end else if (wrap) m_ready = 1;
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (m_valid && !done) begin
            bit exp_clk;
            logic [7:0] exp_rd;
            exp_clk = (m_act == 0) ? m_undiv : (((m_cnt >> (m_act - 1)) % 2) == 1);
            exp_rd  = {m_ready, 3'(m_div), 1'b0, 3'(m_src)};
            total++;
            if (sysclk !== exp_clk) begin
                bad++;
                $display("FAIL R5 R6 sysclk at cycle %0d: got %b expected %b", cyc, sysclk, exp_clk);
            end
            total++;
            if (rd_data !== exp_rd) begin
                bad++;
                $display("FAIL R2 R7 register at cycle %0d: got %h expected %h", cyc, rd_data, exp_rd);
            end
            total++;
            if (div_active !== (m_div != 0)) begin
                bad++;
                $display("FAIL R8 div flag at cycle %0d: got %b expected %b", cyc, div_active, m_div != 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired: got %0d cycles expected at most %0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period(output int p);
        bit prev;
        int n;
        p = -1;
        prev = sysclk;
        n = 0;
        while (!(sysclk && !prev) && n < 5000) begin
            prev = sysclk; @(negedge clk); n++;
        end
        prev = sysclk; @(negedge clk);
        n = 1;
        while (!(sysclk && !prev) && n < 5000) begin
            prev = sysclk; @(negedge clk); n++;
        end
        p = n;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rd_data[7] && n < 20000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int p, lat;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset value
        check("R1 reset register", int'(rd_data), 'h12);
        check("R8 flag at reset divide 2", int'(div_active), 1);

        // R9 R6: low-power/8 divided by 2 (period 4*8*2)
        wait_ready(lat);
        check("R7 ready after first wrap", int'(rd_data[7]), 1);
        period(p);
        check("R9 low-power/8 at divide 2 period", p, 64);

        // R4: precision source at divide 1
        write_reg(8'h00);
        check("R8 flag at divide 1", int'(div_active), 0);
        wait_ready(lat);
        idle(40);
        period(p);
        check("R4 precision source period", p, 6);

        // R3: reserved source code ignored
        write_reg(8'h05);
        check("R3 source field after reserved write", int'(rd_data[2:0]), 0);
        idle(40);
        period(p);
        check("R3 source still precision", p, 6);

        // R2: bit 3 and bit 7 writes
        write_reg(8'h89);
        check("R2 bit 7 not writable", int'(rd_data[7]), 0);
        check("R2 bit 3 reads zero", int'(rd_data[3]), 0);
        check("R4 external code taken", int'(rd_data[2:0]), 1);
        wait_ready(lat);
        idle(40);
        period(p);
        check("R4 external source period", p, 10);

        // R6 R7: divide by 128 on external source
        write_reg(8'h71);
        wait_ready(lat);
        total++;
        if (lat > 1300) begin
            bad++;
            $display("FAIL R7 ready latency: got %0d expected at most 1300", lat);
        end
        period(p);
        check("R6 divide 128 period", p, 1280);

        // R6: divide by 8 on real-time-clock source
        write_reg(8'h33);
        wait_ready(lat);
        idle(60);
        period(p);
        check("R6 real-time-clock divide 8 period", p, 112);

        // R4: raw low-power source at divide 1
        write_reg(8'h04);
        wait_ready(lat);
        idle(40);
        period(p);
        check("R4 low-power source period", p, 4);

        // R5: request redirected during a switch
        write_reg(8'h00);
        write_reg(8'h03);
        idle(60);
        period(p);
        check("R5 redirected switch ends on real-time-clock", p, 14);

        idle(20);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule